// File: doc/BRIEF.md
# DMA Translation Entry Table

This block keeps, for one DMA-capable device, a table of 64-bit translation entries. Each entry governs one fixed-size page of the device's DMA window. The number of entries is fixed at elaboration as the window size divided by the page size. Every entry comes out of reset as zero, which grants no access.

Software installs an entry through a write port. The write gives an I/O bus address and a 64-bit value, and the port answers one cycle later with a success or parameter-error status.

A range-check port takes a start address, a byte length and an access mask. It walks every page that the byte range touches, one page per clock, and reports whether all of those pages grant every bit of the mask. It stops at the first page that does not.

A combinational lookup port hands the raw entry of any page index to a downstream address translator.

Top module: `xlat_entry_table`

## Requirements
- R1: After reset every entry reads as zero, `wr_done`, `chk_done` and `chk_busy` are low.
- R2: A write ignores the page-offset bits [PAGE_SHIFT-1:0] of `wr_addr` and stores into entry index `wr_addr >> PAGE_SHIFT`.
- R3: A write whose page-aligned address is at or above WINDOW_BYTES is rejected: one cycle later `wr_done`=1 and `wr_err`=1, and no entry changes.
- R4: An in-window write stores the full 64-bit value, and one cycle later `wr_done`=1 and `wr_err`=0 (`wr_err` 0 means success, 1 means parameter error).
- R5: `lk_entry` shows the entry at `lk_index` combinationally. A write to that entry in the same cycle shows the old value until the clock edge and the new value after it.
- R6: A range check covers pages `chk_addr >> PAGE_SHIFT` through `(chk_addr + chk_len - 1) >> PAGE_SHIFT` inclusive, examining one page per clock. A passing range of N pages raises `chk_done` with `chk_pass`=1 at the Nth clock edge after the edge that accepted `chk_start`.
- R7: A page passes only when (entry AND `chk_mask`) equals `chk_mask`. The first failing page ends the check at the edge that examines it, with `chk_done`=1 and `chk_pass`=0.
- R8: A page index at or beyond the table size is examined as an all-zero entry.
- R9: A check with `chk_len`=0 completes at the accepting edge itself, with `chk_done`=1 and `chk_pass`=1.
- R10: `chk_start` is ignored while `chk_busy` is high. `chk_done` is a one-cycle pulse and is never high together with `chk_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Install-entry request |
| wr_addr | input | ADDR_W | I/O bus address of the entry to install |
| wr_entry | input | 64 | Entry value |
| wr_done | output | 1 | Status valid, one cycle after the request |
| wr_err | output | 1 | 1 = parameter error, 0 = success |
| chk_start | input | 1 | Start a range check |
| chk_addr | input | ADDR_W | First byte address of the range |
| chk_len | input | ADDR_W | Range length in bytes |
| chk_mask | input | 64 | Access bits that every page must grant |
| chk_busy | output | 1 | Range walk in progress |
| chk_done | output | 1 | Check finished (pulse) |
| chk_pass | output | 1 | Result, valid with `chk_done` |
| lk_index | input | IDX_W | Page index to look up |
| lk_entry | output | 64 | Raw entry at `lk_index` |

## Verification
The bench builds the block with its default parameters: a 64 KiB window, 4 KiB pages and a 32-bit address, which gives a 16-entry table. At that size the top page, the first address past the window and the all-ones address are each reachable with a single write. Ranges that spill one byte beyond the last page probe the handling of pages outside the table. Multi-page walks of up to five pages stay short enough to count their exact completion cycle, including the cycle at which an early failure ends the walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned ENTRY_W = 64;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_SCAN = 1'b1
    } walk_state_e;

    typedef enum logic {
        WST_OK       = 1'b0,
        WST_BADPARAM = 1'b1
    } wr_status_e;

    // True when every bit requested by mask is set in the entry.
    function automatic logic entry_grants(input entry_t e, input entry_t m);
        return (e & m) == m;
    endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned PG_W    = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  entry_t           wdata,
    input  logic [IDX_W-1:0] lk_idx,
    output entry_t           lk_data,
    input  logic [PG_W-1:0]  pg_idx,
    output entry_t           pg_data
);

    entry_t            mem [ENTRIES];
    logic [ENTRIES-1:0] hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_hit
        assign hit[g] = we && (widx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (hit[i]) begin
                mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        lk_data = '0;
        if (32'(lk_idx) < ENTRIES) begin
            lk_data = mem[lk_idx];
        end
    end

    always_comb begin
        pg_data = '0;
        if (64'(pg_idx) < 64'(ENTRIES)) begin
            pg_data = mem[pg_idx[IDX_W-1:0]];
        end
    end

    // R4: an accepted write is present in the array after the edge
    a_r4_entry_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/xlat_wr_port.sv
module xlat_wr_port
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned PAGE_SHIFT   = 12,
    parameter int unsigned WINDOW_BYTES = 65536,
    parameter int unsigned IDX_W        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  entry_t            wr_entry,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_idx,
    output entry_t            st_data,
    output logic              wr_done,
    output logic              wr_err
);

    localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [ADDR_W-1:0] aligned;
    logic              in_window;
    wr_status_e        status;

    assign aligned   = wr_addr & ~OFFS_MASK;
    assign in_window = 64'(aligned) < 64'(WINDOW_BYTES);
    assign status    = in_window ? WST_OK : WST_BADPARAM;

    assign st_we   = wr_valid && in_window;
    assign st_idx  = IDX_W'(aligned >> PAGE_SHIFT);
    assign st_data = wr_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_done <= 1'b0;
            wr_err  <= 1'b0;
        end else begin
            wr_done <= wr_valid;
            wr_err  <= wr_valid && (status == WST_BADPARAM);
        end
    end

    // R3: out-of-window requests come back as parameter errors
    a_r3_reject: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && 64'(wr_addr) >= 64'(WINDOW_BYTES)) |=> (wr_done && wr_err));

    // R4: in-window requests come back as success
    a_r4_accept: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && 64'(wr_addr) < 64'(WINDOW_BYTES)) |=> (wr_done && !wr_err));

endmodule

// File: rtl/xlat_range_walk.sv
module xlat_range_walk
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned PG_W       = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_start,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [ADDR_W-1:0] chk_len,
    input  entry_t            chk_mask,
    output logic [PG_W-1:0]   pg_idx,
    input  entry_t            pg_data,
    output logic              chk_busy,
    output logic              chk_done,
    output logic              chk_pass
);

    typedef struct packed {
        logic [PG_W-1:0] cur;
        logic [PG_W-1:0] last;
        entry_t          mask;
    } walk_ctx_t;

    walk_state_e     state;
    walk_ctx_t       ctx;
    logic [ADDR_W:0] end_byte;
    logic [PG_W-1:0] first_pg;
    logic [PG_W-1:0] last_pg;
    logic            page_ok;

    assign end_byte = {1'b0, chk_addr} + {1'b0, chk_len} - {{ADDR_W{1'b0}}, 1'b1};
    assign first_pg = PG_W'(chk_addr >> PAGE_SHIFT);
    assign last_pg  = PG_W'(end_byte >> PAGE_SHIFT);

    assign pg_idx   = ctx.cur;
    assign page_ok  = entry_grants(pg_data, ctx.mask);
    assign chk_busy = (state == WALK_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WALK_IDLE;
            ctx      <= '0;
            chk_done <= 1'b0;
            chk_pass <= 1'b0;
        end else begin
            chk_done <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (chk_start) begin
                        if (chk_len == '0) begin
                            chk_done <= 1'b1;
                            chk_pass <= 1'b1;
                        end else begin
                            state    <= WALK_SCAN;
                            ctx.cur  <= first_pg;
                            ctx.last <= last_pg;
                            ctx.mask <= chk_mask;
                        end
                    end
                end
                WALK_SCAN: begin
                    if (!page_ok) begin
                        chk_done <= 1'b1;
                        chk_pass <= 1'b0;
                        state    <= WALK_IDLE;
                    end else if (ctx.cur == ctx.last) begin
                        chk_done <= 1'b1;
                        chk_pass <= 1'b1;
                        state    <= WALK_IDLE;
                    end else begin
                        ctx.cur <= ctx.cur + 1'b1;
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    // R9: empty range finishes at once with a pass
    a_r9_zero_len: assert property (@(posedge clk) disable iff (rst)
        (chk_start && !chk_busy && chk_len == '0) |=> (chk_done && chk_pass));

    // R10: done never overlaps the walk
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> !chk_busy);

    // R7: a page lacking a mask bit ends the walk with a fail
    a_r7_fail_stops: assert property (@(posedge clk) disable iff (rst)
        (chk_busy && !entry_grants(pg_data, ctx.mask)) |=> (chk_done && !chk_pass && !chk_busy));

    // R6: a granting page that is not the last advances by one
    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        (chk_busy && entry_grants(pg_data, ctx.mask) && ctx.cur != ctx.last)
            |=> (chk_busy && ctx.cur == $past(ctx.cur) + 1'b1));

    // R10: a start during a walk does not restart it
    a_r10_ignore: assert property (@(posedge clk) disable iff (rst)
        (chk_busy && chk_start && !entry_grants(pg_data, ctx.mask)) |=> !chk_busy);

endmodule

// File: rtl/xlat_entry_table.sv
module xlat_entry_table
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned PAGE_SHIFT   = 12,
    parameter int unsigned WINDOW_BYTES = 65536,
    localparam int unsigned ENTRIES     = WINDOW_BYTES >> PAGE_SHIFT,
    localparam int unsigned IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned PG_W        = ADDR_W - PAGE_SHIFT + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0]  wr_entry,
    output logic                wr_done,
    output logic                wr_err,
    input  logic                chk_start,
    input  logic [ADDR_W-1:0]   chk_addr,
    input  logic [ADDR_W-1:0]   chk_len,
    input  logic [ENTRY_W-1:0]  chk_mask,
    output logic                chk_busy,
    output logic                chk_done,
    output logic                chk_pass,
    input  logic [IDX_W-1:0]    lk_index,
    output logic [ENTRY_W-1:0]  lk_entry
);

    logic             st_we;
    logic [IDX_W-1:0] st_idx;
    entry_t           st_data;
    logic [PG_W-1:0]  pg_idx;
    entry_t           pg_data;

    xlat_wr_port #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .WINDOW_BYTES(WINDOW_BYTES),
        .IDX_W       (IDX_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_entry(wr_entry),
        .st_we   (st_we),
        .st_idx  (st_idx),
        .st_data (st_data),
        .wr_done (wr_done),
        .wr_err  (wr_err)
    );

    xlat_store #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W),
        .PG_W   (PG_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (st_we),
        .widx   (st_idx),
        .wdata  (st_data),
        .lk_idx (lk_index),
        .lk_data(lk_entry),
        .pg_idx (pg_idx),
        .pg_data(pg_data)
    );

    xlat_range_walk #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PG_W      (PG_W)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .chk_start(chk_start),
        .chk_addr (chk_addr),
        .chk_len  (chk_len),
        .chk_mask (chk_mask),
        .pg_idx   (pg_idx),
        .pg_data  (pg_data),
        .chk_busy (chk_busy),
        .chk_done (chk_done),
        .chk_pass (chk_pass)
    );

    // R3: a rejected write changes nothing visible at the lookup port
    a_r3_no_change: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_err == 1'b0 && 64'(wr_addr) >= 64'(WINDOW_BYTES) && $stable(lk_index))
            |=> (lk_entry == $past(lk_entry) || !$stable(lk_index)));

endmodule

// File: tb/sim_xlat_entry_table.sv
module sim_xlat_entry_table;

    localparam int NW = 8;
    localparam int NC = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [63:0] wr_entry = '0;
    logic        wr_done, wr_err;
    logic        chk_start = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [31:0] chk_len = '0;
    logic [63:0] chk_mask = '0;
    logic        chk_busy, chk_done, chk_pass;
    logic [3:0]  lk_index = '0;
    logic [63:0] lk_entry;

    int total = 0;
    int bad = 0;
    logic [63:0] model [16];

    always #2 clk = ~clk;

    xlat_entry_table u0 (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_entry(wr_entry),
        .wr_done(wr_done), .wr_err(wr_err),
        .chk_start(chk_start), .chk_addr(chk_addr), .chk_len(chk_len), .chk_mask(chk_mask),
        .chk_busy(chk_busy), .chk_done(chk_done), .chk_pass(chk_pass),
        .lk_index(lk_index), .lk_entry(lk_entry)
    );

    // write vectors: address, entry value, expected error flag
    localparam logic [31:0] WA [NW] = '{32'h0000_0123, 32'h0000_1FFF, 32'h0000_2000, 32'h0000_3ABC,
                                        32'h0000_F000, 32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_4000};
    localparam logic [63:0] WD [NW] = '{64'hDEAD_0000_0000_0003, 64'h0000_0001_0000_0003, 64'h1, 64'h2,
                                        64'h8000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 64'h3};
    localparam logic        WE [NW] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    // check vectors: address, length, mask, expected pass, expected cycles to done
    localparam logic [31:0] CA [NC] = '{32'h0010, 32'h0FF0, 32'h0000, 32'h0000, 32'h2000, 32'h3000,
                                        32'h6000, 32'hF000, 32'hF000, 32'hF000, 32'h6000};
    localparam logic [31:0] CL [NC] = '{32'h10, 32'h20, 32'h5000, 32'h3000, 32'h2000, 32'h1,
                                        32'h0, 32'h1000, 32'h1001, 32'h1001, 32'h1};
    localparam logic [7:0]  CM [NC] = '{8'd3, 8'd3, 8'd1, 8'd1, 8'd2, 8'd2, 8'd3, 8'd3, 8'd0, 8'd1, 8'd0};
    localparam logic        CP [NC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam int          CC [NC] = '{2, 3, 5, 4, 2, 2, 1, 2, 3, 3, 2};

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [63:0] d, input logic e);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_entry = d;
        @(negedge clk);
        wr_valid = 1'b0;
        check(wr_done == 1'b1, "R4 wr_done", 64'(wr_done), 64'd1);
        check(wr_err == e, e ? "R3 wr_err" : "R4 wr_err", 64'(wr_err), 64'(e));
        if (!e) model[a[15:12]] = d;
    endtask

    task automatic do_check(input logic [31:0] a, input logic [31:0] l, input logic [63:0] m,
                            input logic exp_pass, input int exp_cyc, input bit poke, input string req);
        int cyc;
        @(negedge clk);
        chk_start = 1'b1; chk_addr = a; chk_len = l; chk_mask = m;
        @(negedge clk);
        chk_start = 1'b0;
        cyc = 1;
        if (poke && !chk_done) begin
            chk_start = 1'b1; chk_addr = 32'h0; chk_len = 32'h0; chk_mask = 64'h0;
        end
        while (!chk_done && cyc < 100) begin
            @(negedge clk);
            chk_start = 1'b0;
            cyc++;
        end
        check(cyc == exp_cyc, req, 64'(cyc), 64'(exp_cyc));
        check(chk_pass == exp_pass, req, 64'(chk_pass), 64'(exp_pass));
        check(chk_busy == 1'b0, "R10 busy with done", 64'(chk_busy), 64'd0);
        @(negedge clk);
        check(chk_done == 1'b0, "R10 done pulse", 64'(chk_done), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(wr_done == 1'b0, "R1 wr_done", 64'(wr_done), 64'd0);
        check(chk_done == 1'b0 && chk_busy == 1'b0, "R1 chk idle", {62'd0, chk_busy, chk_done}, 64'd0);
        for (int i = 0; i < 16; i++) begin
            lk_index = 4'(i); #1;
            check(lk_entry == 64'd0, "R1 entry zero", lk_entry, 64'd0);
        end

        // R2/R3/R4: write vector table
        for (int v = 0; v < NW; v++) begin
            do_write(WA[v], WD[v], WE[v]);
            if (!WE[v]) begin
                lk_index = WA[v][15:12]; #1;
                check(lk_entry == WD[v], "R2 stored at aligned index", lk_entry, WD[v]);
            end
        end
        // R3: rejected writes left every entry as modelled
        for (int i = 0; i < 16; i++) begin
            lk_index = 4'(i); #1;
            check(lk_entry == model[i], "R3 table unchanged", lk_entry, model[i]);
        end

        // R5: same-cycle write and lookup
        @(negedge clk);
        lk_index = 4'd5;
        wr_valid = 1'b1; wr_addr = 32'h0000_5000; wr_entry = 64'h0000_0000_1234_5002;
        #1;
        check(lk_entry == 64'd0, "R5 old value same cycle", lk_entry, 64'd0);
        @(negedge clk);
        wr_valid = 1'b0;
        model[5] = 64'h0000_0000_1234_5002;
        check(lk_entry == model[5], "R5 new value next cycle", lk_entry, model[5]);

        // R6/R7/R8/R9: range-check vector table
        for (int v = 0; v < NC; v++) begin
            do_check(CA[v], CL[v], 64'(CM[v]), CP[v], CC[v], 1'b0,
                     (CL[v] == 0) ? "R9 zero length" :
                     (CA[v] == 32'hF000 && CL[v] == 32'h1001) ? "R8 beyond window" :
                     CP[v] ? "R6 range pass" : "R7 range fail");
        end

        // R10: a start during a walk is ignored
        do_check(32'h0, 32'h5000, 64'h1, 1'b0, 5, 1'b1, "R10 start ignored while busy");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule